// File: doc/BRIEF.md
# Serial Flash Command Engine

This peripheral runs one serial NOR flash transaction each time software launches it through a small register port. Software first writes a command word. The command word holds the opcode, the direction of the data phase, whether an address follows, whether a data phase follows, and the byte count minus one. Software then writes the start register with the target address, a mode byte and the launch bit. The engine drives chip-select low and shifts out the opcode. If the command asks for it, the engine then shifts out three address bytes. Last comes the data phase, after which chip-select is released.

Data for the data phase moves through an on-chip byte buffer mapped at offset 0x200. For a program, software fills the buffer before launching. For an identification read, software collects the received bytes from the buffer afterwards. While the transfer runs, the launch bit reads back as 1, and a single-cycle completion pulse is provided for use as an interrupt. The erase and program marker bits of the command word are held and brought out as flags, with no effect on the wire sequence.

Top module: `sfc_engine`

## Requirements
- R1: After reset the command word and the start register read 0, every buffer byte is 0, chip-select is high, the serial clock is low and the completion pulse is low.
- R2: Chip-select is low only while a transaction is in progress, and the serial clock is low whenever chip-select is high.
- R3: Once launched, the first byte shifted out is command bits [7:0], MSB-first. The total number of serial clock pulses with chip-select low is 8 × (1 + 3·A + D·(N+1)), where A is command bit 31, D is command bit 15 and N is command bits [25:16].
- R4: When command bit 31 is set, three address bytes follow the opcode. They are four zero bits followed by start-register bits [27:8], shifted MSB-first.
- R5: The serial clock idles low, and the data-out line changes only while the clock is low (SPI mode 0). The data-in line is sampled on each rising clock edge.
- R6: The start register at offset 4 reads {3'b000, busy, address[19:0], mode[7:0]}, so bit 28 is 1 while a transaction is in progress. A write with bit 28 clear only updates the address and mode fields and launches nothing.
- R7: When bit 15 and bit 14 are both set, the data phase reads from the flash. Received byte j goes into buffer byte j, and the data-out line is held at 0. Buffer word k at offset 0x200+4k returns byte 4k in bits [7:0] through byte 4k+3 in bits [31:24].
- R8: When bit 15 is set and bit 14 is clear, buffer bytes 0..N are shifted out in order. Buffer indices wrap modulo the buffer size.
- R9: Bus writes to the command word, the start register or the buffer while a transaction is in progress have no effect.
- R10: The completion output is high for exactly one cycle, which is the first cycle in which start-register bit 28 reads 0 after a transaction.
- R11: The erase flag output follows command bit 11 and the program flag output follows command bit 12. Neither changes the wire sequence.
- R12: Each high phase of the serial clock lasts exactly CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register port access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | BUS_AW | Byte offset within the peripheral |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed location |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| flag_erase | output | 1 | Held erase marker from the command word |
| flag_program | output | 1 | Held program marker from the command word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle. The checker confirms that chip-select stays high while idle and that the clock stays low with chip-select high. It confirms that the data-out line is stable across each clock high phase and that every high phase lasts exactly the divider length. It also confirms that the completion pulse coincides with the busy bit falling and that the command word cannot move during a transfer. Other behaviour is visible only through the bench's scenarios. This covers the byte order of opcode, address and data, the pulse count for each combination of address and data, the little-endian placement of received bytes, and the wrap of the buffer index. It also covers the ignoring of bus writes issued mid-transfer, which the bench shows by reading the registers and buffer back afterwards.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int LAUNCH_BIT = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSLO,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_CSHI
  } seq_e;

  function automatic logic [7:0] f_opcode(input logic [31:0] c);
    return c[7:0];
  endfunction

  function automatic logic f_is_read(input logic [31:0] c);
    return c[14];
  endfunction

  function automatic logic f_has_data(input logic [31:0] c);
    return c[15];
  endfunction

  function automatic logic f_has_addr(input logic [31:0] c);
    return c[31];
  endfunction

  function automatic logic [9:0] f_len_m1(input logic [31:0] c);
    return c[25:16];
  endfunction

  // Address byte k of the 24-bit wire address built from a 20-bit field.
  function automatic logic [7:0] f_addr_byte(input logic [19:0] a, input logic [1:0] k);
    case (k)
      2'd0:    return {4'h0, a[19:16]};
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  function automatic logic [31:0] f_start_word(input logic busy, input logic [19:0] a,
                                               input logic [7:0] mode);
    return {3'b000, busy, a, mode};
  endfunction

endpackage

// File: rtl/sfc_buffer.sv
module sfc_buffer #(
  parameter int BYTES = 256,
  localparam int WORDS  = BYTES / 4,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [WIDX_W-1:0] bw_idx,
  input  logic [31:0]       bw_data,
  input  logic              ew_en,
  input  logic [IDX_W-1:0]  ew_idx,
  input  logic [7:0]        ew_data,
  input  logic [WIDX_W-1:0] br_idx,
  output logic [31:0]       br_data,
  input  logic [IDX_W-1:0]  er_idx,
  output logic [7:0]        er_data
);

  logic [7:0] mem [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'h00;
    end else begin
      if (bw_en) begin
        for (int b = 0; b < 4; b++) mem[{bw_idx, 2'(b)}] <= bw_data[8*b +: 8];
      end
      if (ew_en) mem[ew_idx] <= ew_data;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign br_data[8*g +: 8] = mem[{br_idx, 2'(g)}];
  end

  assign er_data = mem[er_idx];

endmodule

// File: rtl/sfc_spi_byte.sv
module sfc_spi_byte #(
  parameter int CLK_DIV = 4,
  localparam int DIV_W = $clog2(CLK_DIV) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);

  logic [7:0]       sh_tx;
  logic [7:0]       sh_rx;
  logic [2:0]       bit_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             active;
  logic             phase_end;

  assign phase_end = (div_cnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tx     <= '0;
      sh_rx     <= '0;
      bit_cnt   <= '0;
      div_cnt   <= '0;
      active    <= 1'b0;
      sck       <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          bit_cnt <= '0;
          div_cnt <= '0;
          sck     <= 1'b0;
        end
      end else if (!phase_end) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi    = sh_tx[7];
  assign rx_byte = sh_rx;

endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int BUF_BYTES = 256,
  parameter int BUS_AW    = 12,
  localparam int BUF_BASE = 'h200,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int WIDX_W   = $clog2(BUF_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              flag_erase,
  output logic              flag_program,
  output logic              done
);

  localparam logic [BUS_AW-1:0] BUF_LO = BUS_AW'(BUF_BASE);
  localparam logic [BUS_AW-1:0] BUF_HI = BUS_AW'(BUF_BASE + BUF_BYTES);

  // Register state
  logic [31:0] cmd_q;
  logic [19:0] addr_q;
  logic [7:0]  mode_q;
  logic        busy_q;
  logic        done_q;
  logic        cs_n_q;
  seq_e        st;
  logic        pend;
  logic [9:0]  byte_idx;

  // Named events
  logic hit_cmd, hit_start, hit_buf;
  logic bus_wr_ok;
  logic launch;
  logic byte_done;
  logic eng_wr;

  // Decode
  logic [BUS_AW-1:0] buf_off;
  assign hit_cmd   = (bus_addr[BUS_AW-1:2] == '0);
  assign hit_start = (bus_addr[BUS_AW-1:2] == (BUS_AW-2)'(1));
  assign hit_buf   = (bus_addr >= BUF_LO) && (bus_addr < BUF_HI);
  assign buf_off   = bus_addr - BUF_LO;
  assign bus_wr_ok = bus_sel && bus_we && !busy_q;
  assign launch    = bus_wr_ok && hit_start && bus_wdata[LAUNCH_BIT];

  // Sequencing decisions
  seq_e       nxt_st;
  seq_e       after_hdr;
  logic [9:0] nxt_idx;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic [7:0] buf_byte;
  logic [31:0] buf_word;

  always_comb begin
    after_hdr = f_has_data(cmd_q) ? ST_DAT : ST_CSHI;
    nxt_st    = st;
    nxt_idx   = byte_idx;
    unique case (st)
      ST_OPC: begin
        nxt_st  = f_has_addr(cmd_q) ? ST_ADR : after_hdr;
        nxt_idx = '0;
      end
      ST_ADR: begin
        if (byte_idx == 10'd2) begin
          nxt_st  = after_hdr;
          nxt_idx = '0;
        end else begin
          nxt_idx = byte_idx + 1'b1;
        end
      end
      ST_DAT: begin
        if (byte_idx == f_len_m1(cmd_q)) nxt_st = ST_CSHI;
        else                             nxt_idx = byte_idx + 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_OPC:  tx_byte = f_opcode(cmd_q);
      ST_ADR:  tx_byte = f_addr_byte(addr_q, byte_idx[1:0]);
      ST_DAT:  tx_byte = f_is_read(cmd_q) ? 8'h00 : buf_byte;
      default: tx_byte = 8'h00;
    endcase
  end

  assign eng_wr = (st == ST_DAT) && byte_done && !pend && f_is_read(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      mode_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      st       <= ST_IDLE;
      pend     <= 1'b0;
      byte_idx <= '0;
    end else begin
      done_q <= 1'b0;
      if (bus_wr_ok && hit_cmd) cmd_q <= bus_wdata;
      if (bus_wr_ok && hit_start) begin
        addr_q <= bus_wdata[27:8];
        mode_q <= bus_wdata[7:0];
      end
      unique case (st)
        ST_IDLE: begin
          if (launch) begin
            st     <= ST_CSLO;
            busy_q <= 1'b1;
            cs_n_q <= 1'b0;
          end
        end
        ST_CSLO: begin
          st       <= ST_OPC;
          pend     <= 1'b1;
          byte_idx <= '0;
        end
        ST_OPC, ST_ADR, ST_DAT: begin
          if (pend) begin
            pend <= 1'b0;
          end else if (byte_done) begin
            st       <= nxt_st;
            byte_idx <= nxt_idx;
            pend     <= (nxt_st != ST_CSHI);
            if (nxt_st == ST_CSHI) cs_n_q <= 1'b1;
          end
        end
        ST_CSHI: begin
          st     <= ST_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  sfc_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (pend),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  sfc_buffer #(.BYTES(BUF_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .bw_en   (bus_wr_ok && hit_buf),
    .bw_idx  (buf_off[IDX_W-1:2]),
    .bw_data (bus_wdata),
    .ew_en   (eng_wr),
    .ew_idx  (byte_idx[IDX_W-1:0]),
    .ew_data (rx_byte),
    .br_idx  (buf_off[IDX_W-1:2]),
    .br_data (buf_word),
    .er_idx  (byte_idx[IDX_W-1:0]),
    .er_data (buf_byte)
  );

  always_comb begin
    if (hit_cmd)        bus_rdata = cmd_q;
    else if (hit_start) bus_rdata = f_start_word(busy_q, addr_q, mode_q);
    else if (hit_buf)   bus_rdata = buf_word;
    else                bus_rdata = '0;
  end

  assign spi_cs_n     = cs_n_q;
  assign done         = done_q;
  assign flag_erase   = cmd_q[11];
  assign flag_program = cmd_q[12];

endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk #(
  parameter int CLK_DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic [31:0] cmd_q
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (sck) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);

  // R2
  sck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R10
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);

  // R9
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));

  // R12
  sck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_cnt == 16'(CLK_DIV)));

endmodule

bind sfc_engine sfc_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy_q),
  .done  (done),
  .cs_n  (spi_cs_n),
  .sck   (spi_sck),
  .mosi  (spi_mosi),
  .cmd_q (cmd_q)
);

// File: tb/sfc_engine_tb.sv
`timescale 1ns/1ps
module sfc_engine_tb;

  localparam int CLK_DIV   = 2;
  localparam int BUF_BYTES = 16;
  localparam int BUS_AW    = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic              flag_erase, flag_program, done;

  always #10 clk = ~clk;

  sfc_engine #(.CLK_DIV(CLK_DIV), .BUF_BYTES(BUF_BYTES), .BUS_AW(BUS_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .flag_erase(flag_erase),
    .flag_program(flag_program), .done(done)
  );

  int nchk = 0;
  int nfail = 0;

  // Flash model
  int         salt = 0;
  int         rises = 0;
  int         csfalls = 0;
  logic [7:0] cap [64];
  logic [7:0] miso_byte;
  logic [7:0] tb_buf [BUF_BYTES];

  function automatic logic [7:0] resp(input int s, input int k);
    return 8'((k * 37 + s * 11 + 90) & 255);
  endfunction

  assign miso_byte = resp(salt, rises / 8);
  assign spi_miso  = miso_byte[3'(7 - (rises % 8))];

  always @(negedge spi_cs_n) begin
    rises = 0;
    csfalls = csfalls + 1;
  end

  always @(posedge spi_sck) begin
    cap[(rises / 8) % 64] = {cap[(rises / 8) % 64][6:0], spi_mosi};
    rises = rises + 1;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [BUS_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_buffer(input string req);
    logic [31:0] w;
    for (int k = 0; k < BUF_BYTES / 4; k++) begin
      bus_read(BUS_AW'('h200 + 4 * k), w);
      check(w == {tb_buf[4*k+3], tb_buf[4*k+2], tb_buf[4*k+1], tb_buf[4*k]}, req, w,
            {tb_buf[4*k+3], tb_buf[4*k+2], tb_buf[4*k+1], tb_buf[4*k]});
    end
  endtask

  // Run one transaction; poke issues writes while busy that must be ignored.
  task automatic run_txn(input logic [31:0] cmd, input logic [19:0] a20,
                         input logic [7:0] mode, input logic poke);
    logic [7:0]  exp_tx [64];
    int          n, hdr, len, wd, dcnt, bad;
    logic [31:0] r;
    salt++;
    len = int'(cmd[25:16]) + 1;
    n = 0;
    exp_tx[n++] = cmd[7:0];
    if (cmd[31]) begin
      exp_tx[n++] = {4'h0, a20[19:16]};
      exp_tx[n++] = a20[15:8];
      exp_tx[n++] = a20[7:0];
    end
    hdr = n;
    if (cmd[15]) begin
      for (int j = 0; j < len; j++) exp_tx[n++] = cmd[14] ? 8'h00 : tb_buf[j % BUF_BYTES];
    end
    bus_write(0, cmd);
    bus_write(4, {3'b001, a20, mode});
    bus_addr = 4;
    #1;
    // R6: launch bit reads back set while busy
    check(bus_rdata[28] == 1'b1, "R6 busy readback", bus_rdata, {3'b001, a20, mode});
    if (poke) begin
      bus_write(0, 32'hFFFF_FFFF);
      bus_write(4, 32'h1FFF_FFFF);
      bus_write(BUS_AW'('h200), 32'hDEAD_BEEF);
      bus_addr = 4;
    end
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    check(wd < 20000, "R10 completion watchdog", wd, 20000);
    #1;
    // R10: completion coincides with launch bit reading 0
    check(done && bus_rdata == {3'b000, a20, mode}, "R10 R6 start reg at done",
          bus_rdata, {3'b000, a20, mode});
    dcnt = 0;
    @(negedge clk);
    if (done) dcnt++;
    check(dcnt == 0, "R10 single-cycle pulse", dcnt, 0);
    // R3: pulse count
    check(rises == 8 * n, "R3 clock pulses", rises, 8 * n);
    bad = 0;
    for (int b = 0; b < n; b++) if (cap[b] != exp_tx[b]) bad++;
    // R3 R4 R8: byte content on the wire
    check(bad == 0, "R3 R4 R8 wire bytes", bad, 0);
    if (cmd[15] && cmd[14]) begin
      for (int j = 0; j < len; j++) tb_buf[j % BUF_BYTES] = resp(salt, hdr + j);
    end
    bus_read(0, r);
    check(r == cmd, "R9 command word kept", r, cmd);
    check_buffer("R7 R9 buffer contents");
  endtask

  logic [31:0] rd;
  int          falls0;
  int          wdog = 0;
  logic        wdog_hit = 1'b0;

  always @(posedge clk) begin
    wdog++;
    if (wdog > 190000 && !wdog_hit) begin
      wdog_hit = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wdog, 190000);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BUF_BYTES; i++) tb_buf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(0, rd);
    check(rd == 0, "R1 command word reset", rd, 0);
    bus_read(4, rd);
    check(rd == 0, "R1 start reg reset", rd, 0);
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0, "R1 pins reset",
          {spi_cs_n, spi_sck, done}, 3'b100);
    check_buffer("R1 buffer reset");

    // Preload buffer through the bus
    for (int k = 0; k < BUF_BYTES / 4; k++) begin
      logic [31:0] w;
      w = 32'h0403_0201 * (k + 1) + 32'h1122_3344;
      bus_write(BUS_AW'('h200 + 4 * k), w);
      for (int b = 0; b < 4; b++) tb_buf[4*k+b] = w[8*b +: 8];
    end
    check_buffer("R7 buffer little-endian write");

    // R6: start write without launch bit
    falls0 = csfalls;
    bus_write(4, 32'h0ABC_DE55);
    repeat (20) @(negedge clk);
    check(csfalls == falls0, "R6 no launch without bit 28", csfalls, falls0);
    bus_read(4, rd);
    check(rd == 32'h0ABC_DE55, "R6 start fields", rd, 32'h0ABC_DE55);

    // Named commands
    run_txn(32'h0003_C09F, 20'h0, 8'h00, 1'b0);  // R7 identification read, 4 bytes
    run_txn(32'h0000_0006, 20'h0, 8'h00, 1'b0);  // R3 opcode only
    run_txn(32'h0000_0004, 20'h0, 8'h00, 1'b0);  // R3 opcode only
    run_txn(32'h8000_0820, 20'h12345, 8'hA5, 1'b0);  // R4 erase with address
    check(flag_erase == 1'b1 && flag_program == 1'b0, "R11 erase flag",
          {flag_erase, flag_program}, 2'b10);
    run_txn(32'h800F_9002, 20'hFEDCB, 8'h3C, 1'b0);  // R8 program 16 bytes
    check(flag_erase == 1'b0 && flag_program == 1'b1, "R11 program flag",
          {flag_erase, flag_program}, 2'b01);

    // R9: writes while busy are ignored
    falls0 = csfalls;
    run_txn(32'h800F_8002, 20'h0F0F0, 8'h11, 1'b1);
    repeat (20) @(negedge clk);
    check(csfalls == falls0 + 1, "R9 no relaunch", csfalls, falls0 + 1);

    // Sweep: address on/off, direction, every length, wrap past buffer end
    for (int ae = 0; ae < 2; ae++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int len = 0; len < BUF_BYTES + 4; len++) begin
          logic [31:0] c;
          c = (32'(ae) << 31) | (32'(len) << 16) | 32'h0000_8000 | (32'(dir) << 14)
              | 32'(8'h30 + len) | (32'(len & 1) << 11) | (32'(len & 2) << 11);
          run_txn(c, 20'(len * 4099 + 5), 8'(len), 1'b0);
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule